// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar presented in BCD (seconds, minutes, hours, date, month and day of week) and raises an alarm when the time arrives at a programmed moment. Six alarm slots, one per calendar field, each hold a comparison value and a private enable bit. A slot whose enable is clear plays no part in the comparison. An alarm therefore fires on a full date and time, or on any partial pattern such as "every minute at second 30".

The comparison runs only when the external timekeeper pulses its one-cycle advance strobe. An alarm fires when the time moves into a matching state, not while it stays there. Each firing sets a sticky status flag that is cleared by a dedicated input. An active-low interrupt line follows one of two modes. In single-event mode the line stays asserted until the status is cleared, and the alarm disarms until it is reprogrammed. In repeating mode every new match drives a fixed-length low pulse.

Top module: `calAlarmTop`

## Requirements
- R1: After reset `alarmStat` is 0, `irqN` is 1, every alarm slot is disabled and the control register is 0.
- R2: Register addresses 0 to 5 select the slots for seconds, minutes, hours, date, month and day of week. In each slot, bit 7 is the enable and bits 6:0 hold the BCD value. The value is compared with the matching 7-bit field of `curTime`, where seconds occupy bits 6:0, minutes 13:7, hours 20:14, date 27:21, month 34:28 and day of week 41:35. The alarm fires at an advance strobe where every enabled slot equals its field. `alarmStat` reads 1 from the cycle after that strobe.
- R3: Fields whose slot has bit 7 clear never prevent a match, whatever their value.
- R4: With no slot enabled, the block never fires.
- R5: Matching is evaluated only in cycles where `tickIn` is 1. A match that holds over consecutive strobes fires once. A new firing needs at least one intervening strobe that does not match.
- R6: Address 6 is the control register: bit 0 lets alarms reach `irqN`, and bit 1 selects repeating mode (1) or single-event mode (0). In single-event mode with bit 0 set, `irqN` stays 0 while `alarmStat` is 1. After one firing, further matches are ignored until any register at addresses 0 to 6 is written.
- R7: In repeating mode every firing drives `irqN` low for exactly `PULSE_LEN` cycles, starting in the cycle after the strobe. `alarmStat` stays 1 until it is cleared.
- R8: With control bit 0 clear, `irqN` stays 1. Firings still set `alarmStat`.
- R9: A `statusClr` pulse clears `alarmStat` in the next cycle. This releases `irqN` in single-event mode. If a firing and a clear fall in the same cycle, the firing wins.
- R10: A write to any address from 0 to 6 makes the next advance strobe unable to fire, even if it matches. That strobe only records whether the time matches. A strobe in the write cycle itself cannot fire either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle strobe: calendar has advanced |
| curTime | input | 42 | Current calendar fields, 7-bit BCD each, seconds lowest |
| regWrEn | input | 1 | Register write enable |
| regWrAddr | input | 3 | Register address (0-5 slots, 6 control) |
| regWrData | input | 8 | Register write data |
| statusClr | input | 1 | Clears the alarm status |
| alarmStat | output | 1 | Sticky alarm status |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with 8-bit registers and `PULSE_LEN` = 3. The short pulse lets the bench trace every interrupt cycle after each strobe while still spacing strobes closely. The bench sweeps whole minutes of seconds, minute boundaries and an hour:minute:second crossing. It does this under several enable patterns: one field only, five fields with day of week excluded, and no field at all. Across these sweeps it compares status and interrupt after every strobe against a model computed from the field arithmetic. Narrow cases cover the write blocking, a clear that coincides with a firing, and an unstrobed match.

// File: rtl/calAlarmPkg.sv
package calAlarmPkg;
  // number of calendar fields compared (sec, min, hour, date, month, dow)
  localparam int CAL_FIELDS = 6;
  // control register bit positions
  localparam int CTRL_IRQ_EN_BIT = 0;
  localparam int CTRL_PULSED_BIT = 1;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic [CAL_FIELDS-1:0] loadField;
    logic                  loadCtrl;
    logic                  blockEdge;
    logic                  sample;
  } dpStrobe_t;
endpackage

// File: rtl/calAlarmDatapath.sv
module calAlarmDatapath
  import calAlarmPkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [REG_W-1:0]              wrData,
  input  logic [CAL_FIELDS*(REG_W-1)-1:0] curTime,
  output logic                          matchRise,
  output logic                          irqEn,
  output logic                          pulsedMode
);
  localparam int VAL_W = REG_W - 1;

  logic [CAL_FIELDS-1:0] fieldEn;
  logic [CAL_FIELDS-1:0] fieldHit;
  logic                  matchNow;
  logic                  prevMatch;

  // one alarm slot per calendar field
  for (genvar i = 0; i < CAL_FIELDS; i++) begin : g_slot
    logic [REG_W-1:0] slotQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.loadField[i]) begin
        slotQ <= wrData;
      end
    end

    assign fieldEn[i]  = slotQ[REG_W-1];
    assign fieldHit[i] = (slotQ[VAL_W-1:0] == curTime[i*VAL_W +: VAL_W]);
  end

  // disabled slots are don't-care; no enabled slot means no match
  assign matchNow = (|fieldEn) && (&(fieldHit | ~fieldEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn      <= 1'b0;
      pulsedMode <= 1'b0;
    end else if (strobe.loadCtrl) begin
      irqEn      <= wrData[CTRL_IRQ_EN_BIT];
      pulsedMode <= wrData[CTRL_PULSED_BIT];
    end
  end

  // match state seen at the last strobe; a write forces it high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMatch <= 1'b0;
    end else if (strobe.blockEdge) begin
      prevMatch <= 1'b1;
    end else if (strobe.sample) begin
      prevMatch <= matchNow;
    end
  end

  assign matchRise = strobe.sample && matchNow && !prevMatch && !strobe.blockEdge;
endmodule

// File: rtl/calAlarmCtrl.sv
module calAlarmCtrl
  import calAlarmPkg::*;
#(
  parameter int PULSE_LEN = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              statusClr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic              matchRise,
  input  logic              irqEn,
  input  logic              pulsedMode,
  output dpStrobe_t         strobe,
  output logic              alarmStat,
  output logic              irqN
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             wrHit;
  logic             armed;
  logic             fire;
  logic [CNT_W-1:0] pulseCnt;

  for (genvar i = 0; i < CAL_FIELDS; i++) begin : g_dec
    assign strobe.loadField[i] = regWrEn && (regWrAddr == ADDR_W'(i));
  end
  assign strobe.loadCtrl  = regWrEn && (regWrAddr == ADDR_W'(CAL_FIELDS));
  assign wrHit            = (|strobe.loadField) || strobe.loadCtrl;
  assign strobe.blockEdge = wrHit;
  assign strobe.sample    = tickIn;

  assign fire = matchRise && (pulsedMode || armed);

  // single-event arming: spent on a firing, restored by any write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (wrHit) begin
      armed <= 1'b1;
    end else if (fire && !pulsedMode) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmStat <= 1'b0;
    end else if (fire) begin
      alarmStat <= 1'b1;
    end else if (statusClr) begin
      alarmStat <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (fire && pulsedMode) begin
      pulseCnt <= CNT_W'(PULSE_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign irqN = !(irqEn && (pulsedMode ? (pulseCnt != '0) : alarmStat));
endmodule

// File: rtl/calAlarmTop.sv
module calAlarmTop
  import calAlarmPkg::*;
#(
  parameter int REG_W     = 8,
  parameter int PULSE_LEN = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            tickIn,
  input  logic [CAL_FIELDS*(REG_W-1)-1:0] curTime,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regWrAddr,
  input  logic [REG_W-1:0]                regWrData,
  input  logic                            statusClr,
  output logic                            alarmStat,
  output logic                            irqN
);
  dpStrobe_t strobe;
  logic      matchRise;
  logic      ctrlIrqEn;
  logic      ctrlPulsed;

  calAlarmDatapath #(.REG_W(REG_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .curTime   (curTime),
    .matchRise (matchRise),
    .irqEn     (ctrlIrqEn),
    .pulsedMode(ctrlPulsed)
  );

  calAlarmCtrl #(.PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .statusClr (statusClr),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .matchRise (matchRise),
    .irqEn     (ctrlIrqEn),
    .pulsedMode(ctrlPulsed),
    .strobe    (strobe),
    .alarmStat (alarmStat),
    .irqN      (irqN)
  );
endmodule

// File: rtl/calAlarmChk.sv
module calAlarmChk
  import calAlarmPkg::*;
#(
  parameter int PULSE_LEN = 8,
  parameter int ADDR_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic              statusClr,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic              alarmStat,
  input logic              irqN,
  input logic              irqEn,
  input logic              pulsedMode
);
  logic wrHit;
  assign wrHit = regWrEn && (regWrAddr <= ADDR_W'(CAL_FIELDS));

  // R5
  stat_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmStat) |-> $past(tickIn));

  // R10
  no_fire_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmStat) |-> !$past(wrHit));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusClr) && !$past(tickIn)) |-> !alarmStat);

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> irqN);

  // R6
  single_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pulsedMode && irqEn && alarmStat && !statusClr && !wrHit) |=> !irqN);

  if (PULSE_LEN > 1) begin : g_pulse
    // R7
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pulsedMode && $fell(irqN) && !wrHit) |=> !irqN);
  end
endmodule

bind calAlarmTop calAlarmChk #(.PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickIn    (tickIn),
  .statusClr (statusClr),
  .regWrEn   (regWrEn),
  .regWrAddr (regWrAddr),
  .alarmStat (alarmStat),
  .irqN      (irqN),
  .irqEn     (ctrlIrqEn),
  .pulsedMode(ctrlPulsed)
);

// File: tb/calAlarmTop_tb.sv
module calAlarmTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN       = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [41:0] curTime = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        statusClr = 1'b0;
  logic        alarmStat;
  logic        irqN;

  int checks = 0;
  int failures = 0;
  int fires = 0;
  bit done = 0;

  // bench model state
  logic [7:0] mSlot [6];
  bit mIrqEn = 0, mPulsed = 0, mPrev = 0, mArmed = 1, mStatus = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calAlarmTop #(.REG_W(8), .PULSE_LEN(PLEN), .ADDR_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .curTime(curTime),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .statusClr(statusClr), .alarmStat(alarmStat), .irqN(irqN)
  );

  function automatic logic [6:0] bcd(int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [7:0] data);
    @(negedge clk);
    regWrEn <= 1'b1; regWrAddr <= 3'(addr); regWrData <= data;
    @(negedge clk);
    regWrEn <= 1'b0;
    if (addr < 6) mSlot[addr] = data;
    else if (addr == 6) begin mIrqEn = data[0]; mPulsed = data[1]; end
    if (addr <= 6) begin mPrev = 1; mArmed = 1; end
  endtask

  // one strobe, then PLEN+1 cycles of interrupt tracing
  task automatic tick(int s, int m, int h, int d, int mo, int w, bit clr, string req);
    logic [6:0] v [6];
    bit any, match, fired;
    v[0] = bcd(s); v[1] = bcd(m); v[2] = bcd(h);
    v[3] = bcd(d); v[4] = bcd(mo); v[5] = bcd(w);
    any = 0; match = 1;
    for (int i = 0; i < 6; i++) begin
      if (mSlot[i][7]) begin
        any = 1;
        if (mSlot[i][6:0] != v[i]) match = 0;
      end
    end
    match = match && any;
    fired = match && !mPrev && (mPulsed || mArmed);
    mPrev = match;
    if (fired) begin
      mStatus = 1; fires++;
      if (!mPulsed) mArmed = 0;
    end else if (clr) mStatus = 0;
    @(negedge clk);
    curTime <= {v[5], v[4], v[3], v[2], v[1], v[0]};
    tickIn <= 1'b1; statusClr <= clr;
    @(negedge clk);
    tickIn <= 1'b0; statusClr <= 1'b0;
    chk(alarmStat == mStatus, {req, " status"}, alarmStat, mStatus);
    for (int k = 1; k <= PLEN + 1; k++) begin
      bit expIrq;
      if (k > 1) @(negedge clk);
      expIrq = !(mIrqEn && (mPulsed ? (fired && k <= PLEN) : mStatus));
      chk(irqN == expIrq, {req, "/R7 irq"}, irqN, expIrq);
    end
  endtask

  task automatic clearStat();
    @(negedge clk); statusClr <= 1'b1;
    @(negedge clk); statusClr <= 1'b0;
    mStatus = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 6; i++) mSlot[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alarmStat == 1'b0, "R1 status", alarmStat, 0);
    chk(irqN == 1'b1, "R1 irq", irqN, 1);

    // R4 nothing enabled: all-zero time equals the zero slot values
    wr(6, 8'h03);
    for (int s = 0; s < 60; s++) tick(s, 0, 0, 0, 0, 0, 0, "R4");
    tick(0, 0, 0, 0, 0, 0, 0, "R4");
    chk(fires == 0, "R4 fires", fires, 0);

    // R2/R6 single event, seconds = 30 only
    wr(6, 8'h01);
    wr(0, 8'h80 | 8'(bcd(30)));
    base = fires;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 60; s++) tick(s, m, 10, 5, 6, 2, 0, "R2/R6");
    chk(fires - base == 1, "R6 single fire", fires - base, 1);
    // R9 clear without strobe
    clearStat();
    chk(alarmStat == 1'b0, "R9 clear", alarmStat, 0);
    chk(irqN == 1'b1, "R9 irq release", irqN, 1);
    for (int s = 25; s < 35; s++) tick(s, 2, 10, 5, 6, 2, 0, "R6 disarmed");

    // R5 unstrobed match has no effect
    wr(0, 8'h80 | 8'(bcd(30)));
    @(negedge clk); curTime <= {42{1'b0}} | 42'(bcd(30));
    repeat (3) @(negedge clk);
    chk(alarmStat == 1'b0, "R5 no strobe", alarmStat, 0);

    // R5 persistent match in repeating mode: minute 5 only
    wr(0, 8'h00);
    wr(1, 8'h80 | 8'(bcd(5)));
    wr(6, 8'h03);
    base = fires;
    for (int m = 4; m < 7; m++)
      for (int s = 0; s < 60; s++) tick(s, m, 1, 1, 1, 1, 0, "R5");
    chk(fires - base == 1, "R5 once per persistence", fires - base, 1);

    // R7 repeating mode, seconds = 30 only: one pulse per minute
    wr(1, 8'h00);
    wr(0, 8'h80 | 8'(bcd(30)));
    base = fires;
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 60; s++) tick(s, m, 1, 1, 1, 1, 0, "R7");
    chk(fires - base == 3, "R7 per minute", fires - base, 3);
    chk(alarmStat == 1'b1, "R7 status sticky", alarmStat, 1);
    clearStat();

    // R3 full date/time, day of week disabled
    wr(6, 8'h01);
    wr(0, 8'h80 | 8'(bcd(0)));
    wr(1, 8'h80 | 8'(bcd(30)));
    wr(2, 8'h80 | 8'(bcd(11)));
    wr(3, 8'h80 | 8'(bcd(1)));
    wr(4, 8'h80 | 8'(bcd(1)));
    wr(5, 8'h00 | 8'(bcd(4)));
    base = fires;
    for (int t = 0; t < 20; t++) tick((50 + t) % 60, (t < 10) ? 29 : 30, 11, 2, 1, 6, 0, "R3 wrong date");
    for (int t = 0; t < 20; t++) tick((50 + t) % 60, (t < 10) ? 29 : 30, 11, 1, 1, 6, 0, "R3");
    chk(fires - base == 1, "R3 dow ignored", fires - base, 1);
    clearStat();

    // R8 interrupt disabled, status still set
    for (int i = 1; i < 6; i++) wr(i, 8'h00);
    wr(0, 8'h80 | 8'(bcd(10)));
    wr(6, 8'h00);
    for (int s = 5; s < 15; s++) tick(s, 0, 0, 0, 0, 0, 0, "R8");
    chk(alarmStat == 1'b1, "R8 status", alarmStat, 1);
    chk(irqN == 1'b1, "R8 irq", irqN, 1);

    // R9 clear coinciding with a firing
    wr(6, 8'h01);
    tick(8, 0, 0, 0, 0, 0, 1, "R9 clear");
    tick(9, 0, 0, 0, 0, 0, 0, "R9");
    tick(10, 0, 0, 0, 0, 0, 1, "R9 fire wins");
    chk(alarmStat == 1'b1, "R9 fire wins", alarmStat, 1);
    clearStat();

    // R10 write blocks the next strobe
    wr(0, 8'h80 | 8'(bcd(20)));
    wr(6, 8'h03);
    tick(19, 0, 0, 0, 0, 0, 0, "R10");
    wr(5, 8'h00);
    base = fires;
    tick(20, 0, 0, 0, 0, 0, 0, "R10 blocked");
    chk(alarmStat == 1'b0, "R10 blocked", alarmStat, 0);
    tick(21, 0, 0, 0, 0, 0, 0, "R10");
    tick(20, 0, 0, 0, 0, 0, 0, "R10 refire");
    chk(fires - base == 1, "R10 after block", fires - base, 1);
    chk(alarmStat == 1'b1, "R10 refire status", alarmStat, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule